// File: doc/BRIEF.md
# Dual-Mode Leading-One Normalizer

This combinational block left-justifies mantissas so that their leading one lands in the most significant position. It works on one 64-bit word as a single wide lane, or as two independent 32-bit lanes. A leading-one detector tree finds the left-shift amount. A barrel shifter then moves the bits by that amount. The counts go to the caller, which subtracts them from the exponent.

The mode input selects how the word is treated. When `wide_i` is 1, bits [63:0] form one lane. When `wide_i` is 0, bits [31:0] form the lower lane and bits [63:32] form the upper lane. The split and joined modes share the same detector tree and the same shifter. The detector halves give the per-lane counts, and joining them gives the wide count. Each shifter stage has one multiplexer per half, plus a third multiplexer that lets bits cross the half boundary in wide mode.

Top module: `lon_dual_norm`

## Requirements
- R1: With `wide_i`=0 and a nonzero upper lane, `norm_o[63:32]` equals `mant_i[63:32]` shifted left by its leading-zero count with zero fill, and `cnt_hi_o` reports that count (0..31).
- R2: With `wide_i`=0 and a nonzero lower lane, `norm_o[31:0]` equals `mant_i[31:0]` shifted left by its leading-zero count with zero fill, and `cnt_lo_o` reports that count.
- R3: With `wide_i`=0, no bit of the lower lane ever reaches `norm_o[63:32]`; an all-zero upper lane stays zero whatever the lower lane holds, and each half keeps its population count.
- R4: With `wide_i`=1, `norm_o` equals `mant_i` shifted left by `cnt_wide_o` as a single 64-bit word, with bits crossing from the lower half into the upper half.
- R5: `cnt_wide_o` is the upper-lane count when the upper lane is nonzero, otherwise 32 plus the lower-lane count.
- R6: An all-zero lane raises its zero flag (`zero_lo_o`, `zero_hi_o`, or `zero_wide_o` for the whole word), reports a count of 0, and leaves that part of `norm_o` at zero.
- R7: Every nonzero lane comes out normalized: bit 63 is set in wide mode; bits 63 and 31 are set for the respective nonzero lanes in split mode.
- R8: `cnt_lo_o`, `cnt_hi_o` and `cnt_wide_o` are computed in both modes, so all three are valid whatever `wide_i` holds.
- R9: An input whose lane is already normalized (top bit set) passes through that lane unchanged with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mant_i | input | 64 | Mantissa word: one wide lane or two 32-bit lanes |
| wide_i | input | 1 | 1 = one 64-bit lane, 0 = two 32-bit lanes |
| norm_o | output | 64 | Left-justified mantissa word |
| cnt_lo_o | output | 5 | Leading-zero count of bits [31:0] |
| cnt_hi_o | output | 5 | Leading-zero count of bits [63:32] |
| cnt_wide_o | output | 6 | Leading-zero count of the full word |
| zero_lo_o | output | 1 | Lower lane is all zero |
| zero_hi_o | output | 1 | Upper lane is all zero |
| zero_wide_o | output | 1 | Whole word is all zero |

## Verification
The hardest case to reach is a wide-mode word with an empty upper half. Only then does the 32-position cross stage fire, combined with the smaller cross-boundary stages, and random data almost never produces a 32-bit run of zeros. The stimulus therefore sweeps a single one through all 64 positions in both modes. It also shifts random words right by a random distance of up to the full lane width, so that long zero runs and exact boundary positions occur often. A reference model checks every output on every clock.

// File: rtl/lon_pkg.sv
package lon_pkg;

   typedef enum logic {
      MODE_SPLIT  = 1'b0,
      MODE_JOINED = 1'b1
   } lane_mode_e;

   function automatic bit is_pow2(input int v);
      return (v >= 4) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lon_lod_tree.sv
// Recursive leading-one detector. Leaves use OR/NOT, joins use AND-gated select.
module lon_lod_tree #(
   parameter  int W  = 32,
   localparam int CW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   output logic          any_o,
   output logic [CW-1:0] cnt_o
);

   generate
      if (W == 2) begin : g_leaf
         assign any_o = din[1] | din[0];
         assign cnt_o = ~din[1];
      end else begin : g_node
         localparam int HW = W / 2;
         logic          any_h;
         logic          any_l;
         logic [CW-2:0] c_h;
         logic [CW-2:0] c_l;

         lon_lod_tree #(.W(HW)) u_hi (
            .din   (din[W-1:HW]),
            .any_o (any_h),
            .cnt_o (c_h)
         );

         lon_lod_tree #(.W(HW)) u_lo (
            .din   (din[HW-1:0]),
            .any_o (any_l),
            .cnt_o (c_l)
         );

         assign any_o = any_h | any_l;
         assign cnt_o = {~any_h,
                         (c_h & {(CW-1){any_h}}) | (c_l & {(CW-1){~any_h}})};
      end
   endgenerate

endmodule

// File: rtl/lon_lod_dual.sv
// Two half-width detectors; their outputs combine into the wide count.
module lon_lod_dual #(
   parameter  int LANE_W = 32,
   localparam int WW     = 2 * LANE_W,
   localparam int CW     = $clog2(LANE_W)
) (
   input  logic [WW-1:0] mant_i,
   output logic [CW-1:0] cnt_lo_o,
   output logic [CW-1:0] cnt_hi_o,
   output logic [CW:0]   cnt_wide_o,
   output logic          zero_lo_o,
   output logic          zero_hi_o,
   output logic          zero_wide_o
);

   logic [1:0]         lane_any;
   logic [1:0][CW-1:0] lane_raw;
   logic [1:0][CW-1:0] lane_cnt;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_lane
         lon_lod_tree #(.W(LANE_W)) u_tree (
            .din   (mant_i[g*LANE_W +: LANE_W]),
            .any_o (lane_any[g]),
            .cnt_o (lane_raw[g])
         );
         assign lane_cnt[g] = lane_raw[g] & {CW{lane_any[g]}};
      end
   endgenerate

   assign cnt_lo_o    = lane_cnt[0];
   assign cnt_hi_o    = lane_cnt[1];
   assign zero_lo_o   = ~lane_any[0];
   assign zero_hi_o   = ~lane_any[1];
   assign zero_wide_o = ~(lane_any[0] | lane_any[1]);

   always_comb begin
      if (lane_any[1])      cnt_wide_o = {1'b0, lane_cnt[1]};
      else if (lane_any[0]) cnt_wide_o = {1'b1, lane_cnt[0]};
      else                  cnt_wide_o = '0;
   end

endmodule

// File: rtl/lon_shl_stage.sv
// One dual-mode shifter stage: per-half muxes plus a boundary-crossing mux.
module lon_shl_stage #(
   parameter  int LANE_W = 32,
   parameter  int SHIFT  = 1,
   localparam int WW     = 2 * LANE_W
) (
   input  logic [WW-1:0] din,
   input  logic          joined_i,
   input  logic          bit_lo_i,
   input  logic          bit_hi_i,
   output logic [WW-1:0] dout
);

   logic [LANE_W-1:0] lo_sh;
   logic [LANE_W-1:0] hi_sh;
   logic [LANE_W-1:0] cross_sh;

   assign lo_sh    = bit_lo_i ? {din[LANE_W-1-SHIFT:0], {SHIFT{1'b0}}}
                              : din[LANE_W-1:0];
   assign hi_sh    = bit_hi_i ? {din[WW-1-SHIFT:LANE_W], {SHIFT{1'b0}}}
                              : din[WW-1:LANE_W];
   assign cross_sh = din[WW-1-SHIFT -: LANE_W];

   assign dout[LANE_W-1:0]  = lo_sh;
   assign dout[WW-1:LANE_W] = (joined_i & bit_hi_i) ? cross_sh : hi_sh;

endmodule

// File: rtl/lon_shl_dual.sv
// Barrel left shifter: one wide-only stage of LANE_W, then CW dual-mode stages.
module lon_shl_dual #(
   parameter  int LANE_W = 32,
   localparam int WW     = 2 * LANE_W,
   localparam int CW     = $clog2(LANE_W)
) (
   input  logic [WW-1:0] din,
   input  logic          joined_i,
   input  logic [CW-1:0] amt_lo_i,
   input  logic [CW-1:0] amt_hi_i,
   input  logic [CW:0]   amt_wide_i,
   output logic [WW-1:0] dout
);

   logic [CW+1:0][WW-1:0] st;

   assign st[0] = din;
   assign st[1] = (joined_i & amt_wide_i[CW]) ? {din[LANE_W-1:0], {LANE_W{1'b0}}}
                                              : din;

   generate
      for (genvar s = 0; s < CW; s++) begin : g_stage
         localparam int B = CW - 1 - s;
         logic b_lo;
         logic b_hi;

         assign b_lo = joined_i ? amt_wide_i[B] : amt_lo_i[B];
         assign b_hi = joined_i ? amt_wide_i[B] : amt_hi_i[B];

         lon_shl_stage #(.LANE_W(LANE_W), .SHIFT(1 << B)) u_stage (
            .din      (st[s+1]),
            .joined_i (joined_i),
            .bit_lo_i (b_lo),
            .bit_hi_i (b_hi),
            .dout     (st[s+2])
         );
      end
   endgenerate

   assign dout = st[CW+1];

endmodule

// File: rtl/lon_dual_norm.sv
module lon_dual_norm #(
   parameter  int LANE_W = 32,
   localparam int WW     = 2 * LANE_W,
   localparam int CW     = $clog2(LANE_W)
) (
   input  logic [WW-1:0] mant_i,
   input  logic          wide_i,
   output logic [WW-1:0] norm_o,
   output logic [CW-1:0] cnt_lo_o,
   output logic [CW-1:0] cnt_hi_o,
   output logic [CW:0]   cnt_wide_o,
   output logic          zero_lo_o,
   output logic          zero_hi_o,
   output logic          zero_wide_o
);

   import lon_pkg::*;

   generate
      if (!is_pow2(LANE_W)) begin : g_bad_lane_w
         $error("lon_dual_norm: LANE_W must be a power of two, at least 4");
      end
   endgenerate

   lane_mode_e mode;
   logic       joined;

   assign mode   = lane_mode_e'(wide_i);
   assign joined = (mode == MODE_JOINED);

   lon_lod_dual #(.LANE_W(LANE_W)) u_lod (
      .mant_i      (mant_i),
      .cnt_lo_o    (cnt_lo_o),
      .cnt_hi_o    (cnt_hi_o),
      .cnt_wide_o  (cnt_wide_o),
      .zero_lo_o   (zero_lo_o),
      .zero_hi_o   (zero_hi_o),
      .zero_wide_o (zero_wide_o)
   );

   lon_shl_dual #(.LANE_W(LANE_W)) u_shl (
      .din        (mant_i),
      .joined_i   (joined),
      .amt_lo_i   (cnt_lo_o),
      .amt_hi_i   (cnt_hi_o),
      .amt_wide_i (cnt_wide_o),
      .dout       (norm_o)
   );

endmodule

// File: rtl/lon_dual_norm_chk.sv
module lon_dual_norm_chk #(
   parameter  int LANE_W = 32,
   localparam int WW     = 2 * LANE_W,
   localparam int CW     = $clog2(LANE_W)
) (
   input logic [WW-1:0] mant_i,
   input logic          wide_i,
   input logic [WW-1:0] norm_o,
   input logic [CW-1:0] cnt_lo_o,
   input logic [CW-1:0] cnt_hi_o,
   input logic [CW:0]   cnt_wide_o,
   input logic          zero_lo_o,
   input logic          zero_hi_o,
   input logic          zero_wide_o
);

   always_comb begin
      if (!$isunknown({mant_i, wide_i})) begin
         // R7: nonzero lanes come out with the top bit set
         if (wide_i && !zero_wide_o)
            p_wide_msb_r7: assert (norm_o[WW-1]) else $error("R7 wide msb");
         if (!wide_i && !zero_hi_o)
            p_hi_msb_r7: assert (norm_o[WW-1]) else $error("R7 upper msb");
         if (!wide_i && !zero_lo_o)
            p_lo_msb_r7: assert (norm_o[LANE_W-1]) else $error("R7 lower msb");
         // R6: an empty lane reports count zero and an empty output
         if (zero_hi_o)
            p_zero_hi_cnt_r6: assert (cnt_hi_o == '0) else $error("R6 upper count");
         if (zero_lo_o)
            p_zero_lo_cnt_r6: assert (cnt_lo_o == '0) else $error("R6 lower count");
         if (zero_wide_o)
            p_zero_wide_r6: assert (cnt_wide_o == '0 && norm_o == '0)
               else $error("R6 wide zero");
         // R5: wide count spans into the lower lane when the upper is empty
         if (zero_hi_o && !zero_lo_o)
            p_wide_cnt_r5: assert (cnt_wide_o == (CW+1)'(LANE_W) + (CW+1)'(cnt_lo_o))
               else $error("R5 wide count");
         // R3: split mode keeps each half's bits inside that half
         if (!wide_i)
            p_split_iso_r3: assert ($countones(norm_o[WW-1:LANE_W]) == $countones(mant_i[WW-1:LANE_W])
                                    && $countones(norm_o[LANE_W-1:0]) == $countones(mant_i[LANE_W-1:0]))
               else $error("R3 split isolation");
         // R4: wide shift loses no bits
         if (wide_i)
            p_wide_pop_r4: assert ($countones(norm_o) == $countones(mant_i))
               else $error("R4 wide population");
      end
   end

endmodule

bind lon_dual_norm lon_dual_norm_chk #(.LANE_W(LANE_W)) u_chk (
   .mant_i      (mant_i),
   .wide_i      (wide_i),
   .norm_o      (norm_o),
   .cnt_lo_o    (cnt_lo_o),
   .cnt_hi_o    (cnt_hi_o),
   .cnt_wide_o  (cnt_wide_o),
   .zero_lo_o   (zero_lo_o),
   .zero_hi_o   (zero_hi_o),
   .zero_wide_o (zero_wide_o)
);

// File: tb/lon_dual_norm_test.sv
module lon_dual_norm_test;

   localparam int LW = 32;

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] mant  = '0;
   logic        wide  = 1'b0;
   logic [63:0] norm;
   logic [4:0]  cnt_lo;
   logic [4:0]  cnt_hi;
   logic [5:0]  cnt_wide;
   logic        zero_lo;
   logic        zero_hi;
   logic        zero_wide;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   lon_dual_norm #(.LANE_W(LW)) uut (
      .mant_i      (mant),
      .wide_i      (wide),
      .norm_o      (norm),
      .cnt_lo_o    (cnt_lo),
      .cnt_hi_o    (cnt_hi),
      .cnt_wide_o  (cnt_wide),
      .zero_lo_o   (zero_lo),
      .zero_hi_o   (zero_hi),
      .zero_wide_o (zero_wide)
   );

   function automatic int lead_zeros(logic [63:0] v, int w);
      for (int i = w - 1; i >= 0; i--)
         if (v[i]) return w - 1 - i;
      return w;
   endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h (mant=%h wide=%0b)",
                  tag, what, act, exp, mant, wide);
      end
   endtask

   task automatic compare();
      logic [31:0] lo, hi, e_lo, e_hi;
      logic [63:0] e_w;
      bit          zl, zh, zw;
      int          cl, ch, cw;
      lo = mant[31:0];
      hi = mant[63:32];
      zl = (lo == 0);
      zh = (hi == 0);
      zw = (mant == 0);
      cl = zl ? 0 : lead_zeros({32'b0, lo}, 32);
      ch = zh ? 0 : lead_zeros({32'b0, hi}, 32);
      cw = zw ? 0 : lead_zeros(mant, 64);
      chk("R6", "zero_lo", 64'(zero_lo), 64'(zl));
      chk("R6", "zero_hi", 64'(zero_hi), 64'(zh));
      chk("R6", "zero_wide", 64'(zero_wide), 64'(zw));
      chk(wide ? "R8" : (zh ? "R6" : "R1"), "cnt_hi", 64'(cnt_hi), 64'(ch));
      chk(wide ? "R8" : (zl ? "R6" : "R2"), "cnt_lo", 64'(cnt_lo), 64'(cl));
      chk(zw ? "R6" : "R5", "cnt_wide", 64'(cnt_wide), 64'(cw));
      if (wide) begin
         e_w = mant << cw;
         chk(zw ? "R6" : (mant[63] ? "R9" : "R4"), "norm wide", norm, e_w);
         chk("R7", "wide msb", 64'(norm[63]), 64'(!zw));
      end else begin
         e_hi = hi << ch;
         e_lo = lo << cl;
         chk(zh ? (zl ? "R6" : "R3") : (hi[31] ? "R9" : "R1"), "norm upper",
             64'(norm[63:32]), 64'(e_hi));
         chk(zl ? "R6" : (lo[31] ? "R9" : "R2"), "norm lower",
             64'(norm[31:0]), 64'(e_lo));
         chk("R7", "upper msb", 64'(norm[63]), 64'(!zh));
         chk("R7", "lower msb", 64'(norm[31]), 64'(!zl));
      end
   endtask

   always @(posedge clk)
      if (rst_n && !done) compare();

   task automatic apply(logic [63:0] v, logic m);
      @(negedge clk);
      mant = v;
      wide = m;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // reset state: zero input gives all zero flags and zero result (R6)
      chk("R6", "reset zero_wide", 64'(zero_wide), 64'd1);
      chk("R6", "reset norm", norm, 64'd0);
      rst_n = 1'b1;

      // single one swept over every position, both modes (R1 R2 R3 R4 R5)
      for (int m = 0; m < 2; m++)
         for (int p = 0; p < 64; p++)
            apply(64'd1 << p, m[0]);

      // boundary patterns (R3 R6 R9)
      apply(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
      apply(64'h0000_0000_8000_0001, 1'b0);
      apply(64'h0000_0000_8000_0001, 1'b1);
      apply(64'h8000_0000_0000_0000, 1'b0);
      apply(64'h0000_0001_FFFF_FFFF, 1'b0);
      apply(64'h0000_0001_FFFF_FFFF, 1'b1);
      apply(64'h0000_0000_0000_0000, 1'b1);

      // random words with random leading-zero runs
      for (int i = 0; i < 3000; i++) begin
         logic [63:0] r;
         int          sw, sl, sh;
         r  = {$urandom(), $urandom()};
         sw = int'($urandom_range(64, 0));
         sl = int'($urandom_range(32, 0));
         sh = int'($urandom_range(32, 0));
         if (i % 2 == 1) apply((sw == 64) ? 64'd0 : (r >> sw), 1'b1);
         else apply({((sh == 32) ? 32'd0 : (r[63:32] >> sh)),
                     ((sl == 32) ? 32'd0 : (r[31:0] >> sl))}, 1'b0);
      end

      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         summary();
         $finish;
      end
   end

endmodule